// File: doc/BRIEF.md
# Serial Audio Link Input-Frame Generator

This block is the codec-side transmitter of the input-frame direction of a time-slotted serial audio link. When it sees a rising frame-sync it takes a snapshot of its inputs and builds a 256-bit frame from them. The frame holds a 16-bit tag slot followed by twelve 20-bit slots. It then shifts the frame out MSB first on one serial data line, one bit per bit clock.

The tag slot carries a codec-ready flag and one valid flag for each of slots 1 to 8. Slot 1 echoes the register index whose read data is in slot 2, and it also carries active-low requests for DAC slots 3 to 8. Slot 2 carries the register read data, or all zeros when slot 2 is not tagged valid. Slots 3 to 8 carry six 16-bit record samples: the local pair, then slave 1, then slave 2. Slots 9 to 12 are always zero. A low-power input holds both the bit clock output and the data output low.

The bit clock output is the block clock gated by the low-power input. Data is launched on the rising edge, so the receiver samples on the falling edge.

Top module: `aclink_frame_tx`

## Requirements
- R1: Frame position 0 is the tag MSB. It appears on `sdata_o` for the bit period that starts at the first rising `clk` edge where `sync_i` is sampled 1 after having been sampled 0. Position p follows p edges later. After position 255, `sdata_o` stays 0 until the next rising sync.
- R2: Tag slot, 16 bits, sent MSB first. Bit 15 is `codec_ready_i`. Bit 14-k is `slot_valid_i[k]` for k = 0..7, where index k stands for slot k+1. Bits 6:0 are 0.
- R3: Slot 1, 20 bits. Bit 19 is 0. Bits 18:12 are `reg_index_i`. Bit 11-k is `dac_req_n_i[k]` for k = 0..5, where index k stands for slot k+3 and 0 means request. Bits 5:0 are 0.
- R4: Slot 2 is `{reg_data_i, 4'b0}` when `slot_valid_i[1]` is 1, and all 20 bits are 0 otherwise.
- R5: Slots 3 to 8 carry `rec_l_i`, `rec_r_i`, `s1_l_i`, `s1_r_i`, `s2_l_i` and `s2_r_i`, in that order. Each sample sits in bits 19:4 and bits 3:0 are 0.
- R6: Slots 9 to 12 (frame positions 176 to 255) are always 0.
- R7: While `low_power_i` is 1, `sdata_o` and `bit_clk_o` are 0. A frame in progress is abandoned, and a sync rise seen during low power starts no frame. A later sync rise after low power ends starts a normal frame.
- R8: Frame contents are those present at the start edge. Input changes during the frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock source |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync; a rise starts a frame |
| low_power_i | input | 1 | Holds link outputs low |
| codec_ready_i | input | 1 | Tag bit 15 |
| slot_valid_i | input | 8 | Valid flags, index 0 is slot 1 |
| reg_index_i | input | 7 | Echoed register index |
| reg_data_i | input | 16 | Register read data |
| dac_req_n_i | input | 6 | Active-low DAC requests, index 0 is slot 3 |
| rec_l_i | input | 16 | Local left record sample |
| rec_r_i | input | 16 | Local right record sample |
| s1_l_i | input | 16 | Slave 1 left sample |
| s1_r_i | input | 16 | Slave 1 right sample |
| s2_l_i | input | 16 | Slave 2 left sample |
| s2_r_i | input | 16 | Slave 2 right sample |
| bit_clk_o | output | 1 | Gated bit clock |
| sdata_o | output | 1 | Serial frame data |

## Verification
Frames are captured bit by bit and split into slots.

One frame uses distinct, asymmetric values in every field with all slots valid. This exposes swapped slots, reversed flag order and shifted padding. A second frame clears the slot 2 valid flag and drops codec ready, using all-ones data, to tell gating of slot 2 apart from plain zero-padding. A third frame changes every input partway through, to show the contents are taken as a snapshot. A low-power sequence cuts a frame short, raises sync during low power, and then recovers; this separates output forcing from frame abort and from sync suppression.

// File: rtl/aclink_frame_tx.sv
module aclink_frame_tx #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12,
  parameter int PCM_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             low_power_i,
  input  logic             codec_ready_i,
  input  logic [7:0]       slot_valid_i,
  input  logic [6:0]       reg_index_i,
  input  logic [15:0]      reg_data_i,
  input  logic [5:0]       dac_req_n_i,
  input  logic [PCM_W-1:0] rec_l_i,
  input  logic [PCM_W-1:0] rec_r_i,
  input  logic [PCM_W-1:0] s1_l_i,
  input  logic [PCM_W-1:0] s1_r_i,
  input  logic [PCM_W-1:0] s2_l_i,
  input  logic [PCM_W-1:0] s2_r_i,
  output logic             bit_clk_o,
  output logic             sdata_o
);
  localparam int FRAME_W = TAG_W + NSLOT * SLOT_W;
  localparam int POS_W   = $clog2(FRAME_W);
  localparam int PAD_W   = SLOT_W - PCM_W;
  localparam int RES_W   = (NSLOT - 8) * SLOT_W;

  logic [7:0]         valid_rev;
  logic [5:0]         req_rev;
  logic [TAG_W-1:0]   tag;
  logic [SLOT_W-1:0]  addr_slot, data_slot;
  logic [FRAME_W-1:0] frame_d, sh;
  logic [POS_W-1:0]   pos;
  logic               active, sync_q, sdata_q, start;

  always_comb begin
    for (int k = 0; k < 8; k++) valid_rev[7-k] = slot_valid_i[k];
    for (int k = 0; k < 6; k++) req_rev[5-k] = dac_req_n_i[k];
  end

  assign tag       = {codec_ready_i, valid_rev, {(TAG_W-9){1'b0}}};
  assign addr_slot = {1'b0, reg_index_i, req_rev, {(SLOT_W-14){1'b0}}};
  assign data_slot = slot_valid_i[1] ? {reg_data_i, {(SLOT_W-16){1'b0}}} : '0;
  assign frame_d   = {tag, addr_slot, data_slot,
                      rec_l_i, {PAD_W{1'b0}}, rec_r_i, {PAD_W{1'b0}},
                      s1_l_i,  {PAD_W{1'b0}}, s1_r_i,  {PAD_W{1'b0}},
                      s2_l_i,  {PAD_W{1'b0}}, s2_r_i,  {PAD_W{1'b0}},
                      {RES_W{1'b0}}};

  assign start = sync_i && !sync_q && !low_power_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      active  <= 1'b0;
      pos     <= '0;
      sh      <= '0;
      sdata_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (low_power_i) begin
        active  <= 1'b0;
        pos     <= '0;
        sdata_q <= 1'b0;
      end else if (start) begin
        active  <= 1'b1;
        pos     <= '0;
        sdata_q <= frame_d[FRAME_W-1];
        sh      <= {frame_d[FRAME_W-2:0], 1'b0};
      end else if (active) begin
        if (pos == POS_W'(FRAME_W-1)) begin
          active  <= 1'b0;
          sdata_q <= 1'b0;
        end else begin
          pos     <= pos + 1'b1;
          sdata_q <= sh[FRAME_W-1];
          sh      <= {sh[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign bit_clk_o = clk & ~low_power_i;
  assign sdata_o   = sdata_q & ~low_power_i;
endmodule

module aclink_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_i,
  input logic       sync_q,
  input logic       low_power_i,
  input logic       codec_ready_i,
  input logic       active,
  input logic [7:0] pos,
  input logic       sdata_q,
  input logic       sdata_o
);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sdata_q);

  p_first_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !sync_q && !low_power_i) |=> (low_power_i || sdata_o == $past(codec_ready_i)));

  p_tag_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos >= 8'd9 && pos <= 8'd15) |-> !sdata_q);

  p_addr_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos == 8'd16) |-> !sdata_q);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos >= 8'd176) |-> !sdata_q);

  p_lp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_power_i |-> !sdata_o);

  p_lp_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_power_i |=> !active);
endmodule

bind aclink_frame_tx aclink_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sync_q(sync_q),
  .low_power_i(low_power_i), .codec_ready_i(codec_ready_i),
  .active(active), .pos(pos), .sdata_q(sdata_q), .sdata_o(sdata_o)
);

// File: tb/tb_aclink_frame_tx.sv
module tb_aclink_frame_tx;
  logic clk = 0, rst_n = 0, sync = 0, lp = 0, rdy = 0;
  logic [7:0]  val = '0;
  logic [6:0]  idx = '0;
  logic [15:0] rdat = '0;
  logic [5:0]  req = '0;
  logic [15:0] rl = '0, rr = '0, al = '0, ar = '0, bl = '0, br = '0;
  logic bclk, sd;
  int total = 0, bad = 0;
  logic [0:255] cap;
  logic [15:0] e_tag;
  logic [19:0] e_s1, e_s2;
  logic [19:0] e_pcm [6];

  always #5 clk = ~clk;

  aclink_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync), .low_power_i(lp),
    .codec_ready_i(rdy), .slot_valid_i(val), .reg_index_i(idx),
    .reg_data_i(rdat), .dac_req_n_i(req),
    .rec_l_i(rl), .rec_r_i(rr), .s1_l_i(al), .s1_r_i(ar),
    .s2_l_i(bl), .s2_r_i(br), .bit_clk_o(bclk), .sdata_o(sd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] fld(input int start, input int w);
    logic [19:0] v = '0;
    for (int i = 0; i < w; i++) v = {v[18:0], cap[start+i]};
    return v;
  endfunction

  task automatic snapshot();
    e_tag = '0; e_tag[15] = rdy;
    for (int k = 0; k < 8; k++) e_tag[14-k] = val[k];
    e_s1 = '0; e_s1[18:12] = idx;
    for (int k = 0; k < 6; k++) e_s1[11-k] = req[k];
    e_s2 = val[1] ? {rdat, 4'h0} : 20'h0;
    e_pcm[0] = {rl, 4'h0}; e_pcm[1] = {rr, 4'h0};
    e_pcm[2] = {al, 4'h0}; e_pcm[3] = {ar, 4'h0};
    e_pcm[4] = {bl, 4'h0}; e_pcm[5] = {br, 4'h0};
  endtask

  task automatic capture(input bit scramble);
    @(negedge clk) sync = 1;
    @(posedge clk);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      cap[p] = sd;
      if (p == 2) sync = 0;
      if (scramble && p == 10) begin
        rdy = ~rdy; val = ~val; idx = ~idx; rdat = ~rdat; req = ~req;
        rl = ~rl; rr = ~rr; al = ~al; ar = ~ar; bl = ~bl; br = ~br;
      end
    end
  endtask

  task automatic check_frame(input string name);
    chk({name, " R2 tag"}, 32'(fld(0, 16)), 32'(e_tag));
    chk({name, " R3 addr"}, 32'(fld(16, 20)), 32'(e_s1));
    chk({name, " R4 data"}, 32'(fld(36, 20)), 32'(e_s2));
    for (int s = 0; s < 6; s++)
      chk($sformatf("%s R5 slot%0d", name, s+3), 32'(fld(56+20*s, 20)), 32'(e_pcm[s]));
    chk({name, " R6 reserved"}, 32'(cap[176:255] != '0), 0);
    @(negedge clk);
    chk({name, " R1 idle after frame"}, 32'(sd), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset sdata", 32'(sd), 0);
    @(posedge clk) #1;
    chk("R7 bit clock runs when not low power", 32'(bclk), 1);
  endtask

  task automatic t_full();
    rdy = 1; val = 8'hFF; idx = 7'h26; rdat = 16'hA5C3; req = 6'b110100;
    rl = 16'h8001; rr = 16'h1234; al = 16'hFEDC; ar = 16'h0F0F; bl = 16'h7FFE; br = 16'hC001;
    snapshot(); capture(0); check_frame("full");
  endtask

  task automatic t_slot2_invalid();
    rdy = 0; val = 8'b1111_1101; idx = 7'h7F; rdat = 16'hFFFF; req = 6'b000011;
    rl = 16'hFFFF; rr = 16'h0001; al = 16'h8000; ar = 16'hFFFF; bl = 16'h0000; br = 16'h5555;
    snapshot(); capture(0); check_frame("s2inv");
    chk("R4 slot2 zero when invalid", 32'(fld(36, 20)), 0);
  endtask

  task automatic t_latched();
    rdy = 1; val = 8'b0101_0011; idx = 7'h11; rdat = 16'h3C3C; req = 6'b101010;
    rl = 16'h0123; rr = 16'h4567; al = 16'h89AB; ar = 16'hCDEF; bl = 16'h2468; br = 16'h1357;
    snapshot(); capture(1); check_frame("R8 latched");
  endtask

  task automatic t_lowpower();
    int ones;
    rdy = 1; val = 8'hFF; rdat = 16'hFFFF; rl = 16'hFFFF;
    @(negedge clk) sync = 1;
    repeat (20) @(negedge clk);
    sync = 0; lp = 1;
    #1 chk("R7 sdata low in low power", 32'(sd), 0);
    @(posedge clk) #1 chk("R7 bit clock low in low power", 32'(bclk), 0);
    @(negedge clk) sync = 1;
    repeat (3) @(negedge clk);
    sync = 0;
    @(negedge clk) lp = 0;
    ones = 0;
    repeat (300) begin
      @(negedge clk);
      if (sd) ones++;
    end
    chk("R7 no frame after abort or sync in low power", 32'(ones), 0);
    snapshot(); capture(0); check_frame("R7 recovery");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full();
    t_slot2_invalid();
    t_latched();
    t_lowpower();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule